// File: doc/BRIEF.md
# Receive Ring Buffer Write Manager

This block places received Ethernet frames into a circular region of an 8 KB byte-wide packet memory. Frames arrive byte by byte on a valid/ready stream from an upstream MAC that has already decoded the line and checked the CRC; the final beat of each frame carries a 16-bit status word. For every accepted frame the block writes the payload starting six bytes past its current write pointer. It then fills those six bytes with a little-endian header: the pointer to where the next frame will start, the payload byte count, and the status word. After the header it advances the write pointer and raises the packet count.

Software walks the ring from its own read position. To free space it strobes a decrement to lower the packet count, and it hands back the next-frame pointer it has just consumed. The block turns that pointer into a protected boundary: the byte just below the next frame, or the ring end when that value falls outside the ring. No write may reach this boundary. A frame that would run into it is abandoned and reported with a one-cycle error pulse. Frames whose status marks them bad, and frames longer than the maximum length, are discarded without a report.

Stream rules: a byte moves on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` drops for the single cycle after reset and for the six cycles in which a header is written. The sender may hold `s_valid` high through those gaps. Software must keep `ring_start` even, keep `ring_end` odd, and place both below 0x1800. The block samples them on the first cycle after reset.

Top module: `rxring_mgr`

## Requirements
- R1: While reset is held, and in the first cycle after it, `s_ready` is low. After that cycle `pkt_count` is 0, `pkt_pending` and `ovf_err` are low, and `rd_ptr` equals `ring_end`.
- R2: For a frame accepted at write pointer W, payload byte k is written at W+6+k. After the last payload byte the six header bytes are written at W..W+5: next pointer low then high, byte count low then high, status low then high.
- R3: The next pointer is the address after the last payload byte, rounded up to an even address. It becomes the write pointer of the next frame.
- R4: Every address that would pass `ring_end` continues at `ring_start`, for both payload and header bytes.
- R5: A frame whose status bit 7 (received OK) is 0 is not committed. No header is written, the write pointer and `pkt_count` do not change, and `ovf_err` stays low.
- R6: A frame longer than MAX_LEN (1518) bytes is discarded silently. No header is written, the count does not change, and there is no error pulse. A frame of exactly MAX_LEN bytes is stored.
- R7: With F free bytes from the write pointer up to `rd_ptr`, payload byte k is written only if 7+k < F. The first byte that fails this test ends all writing for the frame. The rest of the frame is accepted and dropped, and `ovf_err` pulses for one cycle after the last beat. The write pointer does not change.
- R8: `pkt_count` rises by one when a header completes. A `pkt_dec` strobe lowers it by one, and a strobe at 0 has no effect. `pkt_pending` is high exactly when the count is nonzero.
- R9: The count saturates at 255. A good frame whose last beat arrives while the count is 255 is dropped with an `ovf_err` pulse, and the count stays at 255.
- R10: A `rd_we` strobe sets `rd_ptr` to `rd_next`−1. If that value is below `ring_start` or above `ring_end`, `rd_ptr` is set to `ring_end` instead.
- R11: `s_ready` is low during the six header-write cycles that follow the last beat of a committed frame.
- R12: No memory write ever lands on the address held in `rd_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_start | input | 13 | First byte of the receive ring (even) |
| ring_end | input | 13 | Last byte of the receive ring (odd) |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Block can take a frame byte |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_status | input | 16 | Frame status, sampled with the last byte; bit 7 = received OK |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 13 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| rd_we | input | 1 | Strobe: load the protected boundary from `rd_next` |
| rd_next | input | 13 | Next-frame pointer consumed by software |
| pkt_dec | input | 1 | Strobe: one frame released |
| rd_ptr | output | 13 | Protected boundary address |
| pkt_count | output | 8 | Frames held in the ring |
| pkt_pending | output | 1 | At least one frame held |
| ovf_err | output | 1 | One-cycle pulse when a frame is lost to lack of room or a full count |

## Verification
A corrupted write pointer shows up directly in the next frame: its header lands at the wrong address, or carries a next pointer that does not match the running sum of frame sizes. So every header check also checks the pointer left by the frame before it. A wrong free-space result shows at the ports as a missing or spurious `ovf_err` pulse one cycle after the last beat, or as a header written over old data. That is why the overflow case is followed at once by a frame that just fits. Counter faults appear on `pkt_count` within one cycle of the header's last write or of a `pkt_dec` strobe.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ADDR_W = 13;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_PAY,
    WS_HDR,
    WS_DROP
  } wr_state_e;

  // advance an address by n bytes, folding past the top back to the bottom
  function automatic addr_t ring_step(addr_t a, logic [2:0] n, addr_t lo, addr_t hi);
    logic [ADDR_W:0] s;
    logic [ADDR_W:0] span;
    s    = {1'b0, a} + {{(ADDR_W-2){1'b0}}, n};
    span = {1'b0, hi} - {1'b0, lo} + (ADDR_W+1)'(1);
    if (s > {1'b0, hi}) s = s - span;
    return s[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/rxr_counter.sv
module rxr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             pending
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic dec_ok;
  assign dec_ok  = dec && (cnt != '0);
  assign full    = (cnt == CMAX);
  assign pending = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   if (!full) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: a lone release lowers the count by exactly one
  a_r8_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R8: release at zero has no effect
  a_r8_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !inc) |=> (cnt == '0));

  // R9: the writer never commits into a full count
  a_r9_no_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && full && !dec));
endmodule

// File: rtl/rxr_release.sv
module rxr_release
  import rxr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init,
  input  addr_t ring_lo,
  input  addr_t ring_hi,
  input  logic  rel_we,
  input  addr_t rel_next,
  output addr_t rd_ptr
);
  addr_t below;
  logic  outside;

  assign below   = rel_next - addr_t'(1);
  assign outside = (below < ring_lo) || (below > ring_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '1;
    end else if (init) begin
      rd_ptr <= ring_hi;
    end else if (rel_we) begin
      rd_ptr <= outside ? ring_hi : below;
    end
  end

  // R10: the boundary always lands inside the ring after an update
  a_r10_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_we && !init) |=> (rd_ptr >= ring_lo && rd_ptr <= ring_hi));
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = 16,
  parameter int ST_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  addr_t           ring_lo,
  input  addr_t           ring_hi,
  input  addr_t           rd_ptr,
  input  logic            cnt_full,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic [ST_W-1:0] in_status,
  output logic            mem_we,
  output addr_t           mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            commit,
  output logic            drop_err
);
  localparam int CW      = LEN_W + 1;
  localparam int OK_BIT  = 7;
  localparam int HDR_LEN = 6;

  wr_state_e        st;
  addr_t            wp, pa, ha, nxt;
  logic [LEN_W-1:0] len;
  logic [ST_W-1:0]  stat;
  logic [2:0]       hidx;
  logic             err_hold;

  logic [ADDR_W:0]  span, free_b;
  addr_t            cur_a, after_a, nxt_c;
  logic [LEN_W-1:0] k;
  logic             taking, take, too_long, no_room;
  logic [15:0]      nxt16, len16, st16;
  logic [7:0]       hdr_byte;

  assign taking   = (st == WS_IDLE) || (st == WS_PAY);
  assign in_ready = !init && (st != WS_HDR);
  assign take     = in_valid && in_ready;

  // bytes free from the write pointer up to the protected boundary
  assign span   = {1'b0, ring_hi} - {1'b0, ring_lo} + (ADDR_W+1)'(1);
  assign free_b = (rd_ptr >= wp) ? ({1'b0, rd_ptr} - {1'b0, wp})
                                 : ({1'b0, rd_ptr} + span - {1'b0, wp});

  assign cur_a    = (st == WS_IDLE) ? ring_step(wp, 3'(HDR_LEN), ring_lo, ring_hi) : pa;
  assign k        = (st == WS_IDLE) ? '0 : len;
  assign too_long = (k >= LEN_W'(MAX_LEN));
  assign no_room  = (CW'(k) + CW'(7)) >= CW'(free_b);
  assign after_a  = ring_step(cur_a, 3'd1, ring_lo, ring_hi);
  assign nxt_c    = after_a[0] ? ring_step(after_a, 3'd1, ring_lo, ring_hi) : after_a;

  assign nxt16 = 16'(nxt);
  assign len16 = 16'(len);
  assign st16  = 16'(stat);

  always_comb begin
    case (hidx)
      3'd0:    hdr_byte = nxt16[7:0];
      3'd1:    hdr_byte = nxt16[15:8];
      3'd2:    hdr_byte = len16[7:0];
      3'd3:    hdr_byte = len16[15:8];
      3'd4:    hdr_byte = st16[7:0];
      default: hdr_byte = st16[15:8];
    endcase
  end

  always_comb begin
    if (st == WS_HDR) begin
      mem_we    = 1'b1;
      mem_addr  = ha;
      mem_wdata = hdr_byte;
    end else begin
      mem_we    = take && taking && !too_long && !no_room;
      mem_addr  = cur_a;
      mem_wdata = in_data;
    end
  end

  assign commit = (st == WS_HDR) && (hidx == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WS_IDLE;
      wp       <= '0;
      pa       <= '0;
      ha       <= '0;
      nxt      <= '0;
      len      <= '0;
      stat     <= '0;
      hidx     <= '0;
      err_hold <= 1'b0;
      drop_err <= 1'b0;
    end else begin
      drop_err <= 1'b0;
      if (init) begin
        wp <= ring_lo;
        st <= WS_IDLE;
      end else begin
        case (st)
          WS_IDLE, WS_PAY: begin
            if (take) begin
              if (too_long || no_room) begin
                if (in_last) begin
                  drop_err <= !too_long;
                  st       <= WS_IDLE;
                end else begin
                  err_hold <= !too_long;
                  st       <= WS_DROP;
                end
              end else begin
                pa  <= after_a;
                len <= k + 1'b1;
                if (!in_last) begin
                  st <= WS_PAY;
                end else if (!in_status[OK_BIT]) begin
                  st <= WS_IDLE;
                end else if (cnt_full) begin
                  drop_err <= 1'b1;
                  st       <= WS_IDLE;
                end else begin
                  nxt  <= nxt_c;
                  stat <= in_status;
                  ha   <= wp;
                  hidx <= '0;
                  st   <= WS_HDR;
                end
              end
            end
          end
          WS_DROP: begin
            if (take && in_last) begin
              drop_err <= err_hold;
              st       <= WS_IDLE;
            end
          end
          WS_HDR: begin
            ha   <= ring_step(ha, 3'd1, ring_lo, ring_hi);
            hidx <= hidx + 1'b1;
            if (hidx == 3'd5) begin
              wp <= nxt;
              st <= WS_IDLE;
            end
          end
          default: st <= WS_IDLE;
        endcase
      end
    end
  end

  // R3: frame starts always sit on even addresses
  a_r3_wp_even: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && st == WS_HDR) |-> !ha[0] || hidx != 3'd0);

  // R4: every write stays inside the ring
  a_r4_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= ring_lo && mem_addr <= ring_hi));

  // R2: a header, once begun, writes on every cycle until it completes
  a_r2_hdr_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WS_HDR && hidx != 3'd5) |=> (st == WS_HDR && mem_we));

  // R11: no stream byte can be taken while a header is going out
  a_r11_hdr_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WS_HDR) |-> !(in_valid && in_ready));
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
  import rxr_pkg::*;
#(
  parameter int MAX_LEN = 1518,
  parameter int CNT_W   = 8,
  parameter int LEN_W   = 16,
  parameter int ST_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     ring_start,
  input  logic [ADDR_W-1:0]     ring_end,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [7:0]            s_data,
  input  logic                  s_last,
  input  logic [ST_W-1:0]       s_status,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic                  rd_we,
  input  logic [ADDR_W-1:0]     rd_next,
  input  logic                  pkt_dec,
  output logic [ADDR_W-1:0]     rd_ptr,
  output logic [CNT_W-1:0]      pkt_count,
  output logic                  pkt_pending,
  output logic                  ovf_err
);
  logic booted, init, commit, cnt_full;

  always_ff @(posedge clk) begin
    if (!rst_n) booted <= 1'b0;
    else        booted <= 1'b1;
  end
  assign init = !booted;

  rxr_release u_rel (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (init),
    .ring_lo  (ring_start),
    .ring_hi  (ring_end),
    .rel_we   (rd_we),
    .rel_next (rd_next),
    .rd_ptr   (rd_ptr)
  );

  rxr_writer #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .ST_W    (ST_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .ring_lo   (ring_start),
    .ring_hi   (ring_end),
    .rd_ptr    (rd_ptr),
    .cnt_full  (cnt_full),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (s_data),
    .in_last   (s_last),
    .in_status (s_status),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .commit    (commit),
    .drop_err  (ovf_err)
  );

  rxr_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (commit),
    .dec     (pkt_dec),
    .cnt     (pkt_count),
    .full    (cnt_full),
    .pending (pkt_pending)
  );

  // R12: the protected boundary byte is never written
  a_r12_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && booted) |-> (mem_addr != rd_ptr));

  // R1: nothing is accepted in the start-up cycle
  a_r1_boot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !s_ready);
endmodule

// File: tb/sim_rxring_mgr.sv
module sim_rxring_mgr;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] ring_start = '0, ring_end = 13'h003F;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic [15:0] s_status = '0;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        rd_we = 1'b0, pkt_dec = 1'b0;
  logic [12:0] rd_next = '0;
  logic [12:0] rd_ptr;
  logic [7:0]  pkt_count;
  logic        pkt_pending, ovf_err;

  int total = 0, bad = 0, errs = 0;
  logic last_ready;
  logic [7:0] bmem [2048];

  always #(CLK_NS/2) clk = ~clk;

  rxring_mgr u0 (
    .clk(clk), .rst_n(rst_n), .ring_start(ring_start), .ring_end(ring_end),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_status(s_status), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_we(rd_we), .rd_next(rd_next), .pkt_dec(pkt_dec),
    .rd_ptr(rd_ptr), .pkt_count(pkt_count), .pkt_pending(pkt_pending),
    .ovf_err(ovf_err)
  );

  always @(posedge clk) if (mem_we) bmem[mem_addr[10:0]] <= mem_wdata;
  always @(negedge clk) if (rst_n && ovf_err) errs++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [12:0] lo, logic [12:0] hi);
    @(negedge clk);
    rst_n = 1'b0; ring_start = lo; ring_end = hi;
    for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
    repeat (2) @(negedge clk);
    check("R1 ready low in reset", 32'(s_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(int n, logic [15:0] st, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b0;
      while (!s_ready) @(negedge clk);
      s_valid = 1'b1; s_data = seed + 8'(i); s_last = (i == n-1); s_status = st;
    end
    @(negedge clk);
    last_ready = s_ready;
    s_valid = 1'b0; s_last = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe_dec();
    @(negedge clk); pkt_dec = 1'b1;
    @(negedge clk); pkt_dec = 1'b0;
  endtask

  task automatic release_to(logic [12:0] nx);
    @(negedge clk); rd_we = 1'b1; rd_next = nx;
    @(negedge clk); rd_we = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(13'h0000, 13'h003F);
    check("R1 count", 32'(pkt_count), 0);
    check("R1 pending", 32'(pkt_pending), 0);
    check("R1 err", 32'(errs), 0);
    check("R1 rd_ptr", 32'(rd_ptr), 32'h3F);
    check("R1 ready after boot", 32'(s_ready), 1);
  endtask

  task automatic t_first_frames();
    send_frame(5, 16'h1280, 8'h10);
    check("R11 ready low in header", 32'(last_ready), 0);
    check("R2 payload first", 32'(bmem[6]), 32'h10);
    check("R2 payload last", 32'(bmem[10]), 32'h14);
    check("R3 next lo", 32'(bmem[0]), 32'h0C);
    check("R2 next hi", 32'(bmem[1]), 32'h00);
    check("R2 len lo", 32'(bmem[2]), 32'h05);
    check("R2 status lo", 32'(bmem[4]), 32'h80);
    check("R2 status hi", 32'(bmem[5]), 32'h12);
    check("R8 count one", 32'(pkt_count), 1);
    check("R8 pending", 32'(pkt_pending), 1);
    send_frame(4, 16'h0081, 8'h20);
    check("R3 second at 0C", 32'(bmem[12]), 32'h16);
    check("R2 second len", 32'(bmem[14]), 32'h04);
    check("R2 second payload", 32'(bmem[18]), 32'h20);
    check("R8 count two", 32'(pkt_count), 2);
  endtask

  task automatic t_bad_status();
    int e0 = errs;
    send_frame(3, 16'h0040, 8'h30);
    check("R5 no header", 32'(bmem[22]), 32'h00);
    check("R5 count kept", 32'(pkt_count), 2);
    check("R5 no error", 32'(errs - e0), 0);
  endtask

  task automatic t_release();
    strobe_dec();
    check("R8 dec", 32'(pkt_count), 1);
    release_to(13'h0016);
    check("R10 next-1", 32'(rd_ptr), 32'h15);
    release_to(13'h0000);
    check("R10 below start", 32'(rd_ptr), 32'h3F);
    release_to(13'h0050);
    check("R10 beyond end", 32'(rd_ptr), 32'h3F);
    release_to(13'h0016);
    check("R10 back", 32'(rd_ptr), 32'h15);
  endtask

  task automatic t_wrap();
    send_frame(40, 16'h0080, 8'h40);
    check("R5 frame lands at old wp", 32'(bmem[22]), 32'h04);
    check("R2 wrap len", 32'(bmem[24]), 32'h28);
    check("R4 byte at ring end", 32'(bmem[63]), 32'h63);
    check("R4 byte at ring start", 32'(bmem[0]), 32'h64);
    check("R4 byte after wrap", 32'(bmem[3]), 32'h67);
    check("R8 count", 32'(pkt_count), 2);
  endtask

  task automatic t_overflow();
    int e0 = errs;
    send_frame(12, 16'h0080, 8'h80);
    check("R7 error pulse", 32'(errs - e0), 1);
    check("R7 count kept", 32'(pkt_count), 2);
    check("R7 no header", 32'(bmem[4]), 32'h80);
    check("R12 boundary untouched", 32'(bmem[21]), 32'h23);
    send_frame(10, 16'h0080, 8'h90);
    check("R7 fits at same wp", 32'(bmem[4]), 32'h14);
    check("R7 fit len", 32'(bmem[6]), 32'h0A);
    check("R7 fit payload", 32'(bmem[10]), 32'h90);
    check("R7 no error on fit", 32'(errs - e0), 1);
    check("R8 count three", 32'(pkt_count), 3);
  endtask

  task automatic t_length_and_count();
    int e0;
    do_reset(13'h0000, 13'h17FF);
    strobe_dec();
    check("R8 dec at zero", 32'(pkt_count), 0);
    e0 = errs;
    send_frame(1518, 16'h0080, 8'h00);
    check("R6 max len lo", 32'(bmem[2]), 32'hEE);
    check("R6 max len hi", 32'(bmem[3]), 32'h05);
    check("R3 max next lo", 32'(bmem[0]), 32'hF4);
    check("R6 max stored", 32'(pkt_count), 1);
    send_frame(1519, 16'h0080, 8'h00);
    check("R6 oversize count", 32'(pkt_count), 1);
    check("R6 oversize silent", 32'(errs - e0), 0);
    check("R6 oversize no header", 32'(bmem[11'h5F4]), 32'h00);
    for (int i = 0; i < 254; i++) send_frame(1, 16'h0080, 8'hA5);
    check("R9 reaches max", 32'(pkt_count), 255);
    send_frame(1, 16'h0080, 8'hA5);
    check("R9 saturated", 32'(pkt_count), 255);
    check("R9 error pulse", 32'(errs - e0), 1);
    strobe_dec();
    check("R8 dec from max", 32'(pkt_count), 254);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_first_frames();
        t_bad_status();
        t_release();
        t_wrap();
        t_overflow();
        t_length_and_count();
      end
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule